// File: doc/BRIEF.md
# Iterative AES Inverse Cipher Core

This core turns one 128-bit AES ciphertext block back into plaintext. It works with keys of 128, 192 or 256 bits. The key schedule is expanded elsewhere and held in a shared word store. The core reads round keys from that store through a word-addressed read port with one cycle of latency. It walks the schedule from the highest words down to words 0..3.

The control logic that owns the core does three things. It presents the ciphertext and a two-bit key-length code, then pulses `start_i`. The core then runs on its own, one round every five cycles: four cycles to fetch the round-key words and one cycle to apply the round. It raises `done_o` for a single cycle when the plaintext is ready on `plain_o`. The control logic turns that pulse into an interrupt.

The state lives in the core, so no external memory holds intermediate data. One combinational round stage serves every round, and the last round skips the column mixing.

Top module: `aes_inv_core`

## Requirements
- R1: While reset is held and right after it is released, `busy_o` and `done_o` are low and `plain_o` is all zeros.
- R2: A `start_i` seen at a clock edge while the core is idle captures `cipher_i` and `key_len_i`, and `busy_o` is high from that edge until the edge that raises `done_o`.
- R3: `key_len_i` sets the round count Nr: code 0 gives 10 rounds (128-bit key), code 1 gives 12 rounds (192-bit key), code 2 gives 14 rounds (256-bit key). The reserved code 3 behaves like code 2.
- R4: `done_o` rises exactly 5·(Nr+1) clock edges after the accepted start edge. It is high for one cycle only, and `busy_o` is low in that same cycle.
- R5: Round-key words are read through `rk_addr_o`, and the word at an address appears on `rk_data_i` one cycle later. The first address after a start is 4·Nr. During an operation every address stays between 0 and 4·Nr+3, and all of that range is used. Within a round key, word 4k+j occupies state bits 127−32j down to 96−32j.
- R6: The first step XORs the ciphertext with the round key at words 4·Nr..4·Nr+3. Each following round uses the key four words lower and applies inverse shift rows, inverse byte substitution, add round key and inverse mix columns, in that order. The final round, which uses words 0..3, leaves out inverse mix columns.
- R7: Inverse shift rows rotates row r of the column-major state right by r byte positions. Inverse mix columns multiplies each column by the circulant matrix (0e, 0b, 0d, 09) over GF(2^8) modulo 0x11B. With the 128-bit key 000102…0f, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a yields 00112233445566778899aabbccddeeff.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its round count, latency and result.
- R9: Between operations, `plain_o` keeps the last result until the next accepted start, whatever `cipher_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only when idle |
| key_len_i | input | 2 | Key length code: 0=128, 1=192, 2 or 3=256 |
| cipher_i | input | 128 | Ciphertext block, column 0 in the top bits |
| rk_addr_o | output | 6 | Word address into the expanded-key store |
| rk_data_i | input | 32 | Key word, valid one cycle after its address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| plain_o | output | 128 | Plaintext result, held until the next start |

## Verification
The hardest situation to reach from the ports is a second start request landing in the middle of a running operation. It carries a different key length and ciphertext, and if it leaked in it would change both the round count and the result. The bench fires such requests at chosen round offsets, including the very first busy cycle and the cycle before completion. It then checks that latency, address range and plaintext still match the first request. Random keys of every length, including the reserved code, are expanded and used to encrypt random plaintext in the bench, so every result is checked against a known original.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

    localparam int WORD_W    = 32;
    localparam int NB        = 4;
    localparam int BLOCK_W   = WORD_W * NB;
    localparam int NBYTES    = BLOCK_W / 8;
    localparam int K_W       = 4;
    localparam int W_W       = 3;
    localparam int RK_ADDR_W = K_W + 2;
    localparam int FETCH_LAST = NB;

    typedef logic [7:0] gf_byte_t;

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [K_W-1:0]      nr;
        logic [K_W-1:0]      k;
        logic [W_W-1:0]      w;
        logic [WORD_W-1:0]   rk0;
        logic [WORD_W-1:0]   rk1;
        logic [WORD_W-1:0]   rk2;
        logic [BLOCK_W-1:0]  st;
    } core_q_t;

    function automatic gf_byte_t gf_xtime(input gf_byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b);
        gf_byte_t p;
        gf_byte_t aa;
        p  = 8'h00;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = gf_xtime(aa);
        end
        return p;
    endfunction

    // x^254 is the multiplicative inverse (and maps 0 to 0)
    function automatic gf_byte_t gf_inv(input gf_byte_t x);
        gf_byte_t r;
        gf_byte_t s;
        r = 8'h01;
        s = x;
        for (int i = 1; i < 8; i++) begin
            s = gf_mul(s, s);
            r = gf_mul(r, s);
        end
        return r;
    endfunction

    function automatic gf_byte_t inv_affine(input gf_byte_t x);
        gf_byte_t r1, r3, r6;
        r1 = {x[6:0], x[7]};
        r3 = {x[4:0], x[7:5]};
        r6 = {x[1:0], x[7:2]};
        return r1 ^ r3 ^ r6 ^ 8'h05;
    endfunction

    function automatic logic [K_W-1:0] rounds_for(input logic [1:0] code);
        case (code)
            2'd0:    return K_W'(10);
            2'd1:    return K_W'(12);
            default: return K_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
    import aes_inv_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic [7:0] byte_o
);
    always_comb begin
        byte_o = gf_inv(inv_affine(byte_i));
    end
endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol
    import aes_inv_pkg::*;
(
    input  logic [WORD_W-1:0] col_i,
    input  logic              bypass_i,
    output logic [WORD_W-1:0] col_o
);
    gf_byte_t a0, a1, a2, a3;
    gf_byte_t m0, m1, m2, m3;

    always_comb begin
        a0 = col_i[31:24];
        a1 = col_i[23:16];
        a2 = col_i[15:8];
        a3 = col_i[7:0];
        m0 = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
        m1 = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
        m2 = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
        m3 = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
        col_o = bypass_i ? col_i : {m0, m1, m2, m3};
    end
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  logic [BLOCK_W-1:0] state_i,
    input  logic [BLOCK_W-1:0] rk_i,
    input  logic               last_i,
    output logic [BLOCK_W-1:0] state_o
);
    logic [BLOCK_W-1:0] shifted;
    logic [BLOCK_W-1:0] subbed;
    logic [BLOCK_W-1:0] keyed;

    // byte (row r, column c) sits at index 4c+r counted from the top
    for (genvar c = 0; c < NB; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int DST = 4 * c + r;
            localparam int SRC = 4 * ((c - r + NB) % NB) + r;
            assign shifted[BLOCK_W-1-8*DST -: 8] = state_i[BLOCK_W-1-8*SRC -: 8];
            aes_inv_sbox i_sbox (
                .byte_i (shifted[BLOCK_W-1-8*DST -: 8]),
                .byte_o (subbed[BLOCK_W-1-8*DST -: 8])
            );
        end
        assign keyed[BLOCK_W-1-WORD_W*c -: WORD_W] =
            subbed[BLOCK_W-1-WORD_W*c -: WORD_W] ^ rk_i[BLOCK_W-1-WORD_W*c -: WORD_W];
        aes_inv_mixcol i_mixcol (
            .col_i    (keyed[BLOCK_W-1-WORD_W*c -: WORD_W]),
            .bypass_i (last_i),
            .col_o    (state_o[BLOCK_W-1-WORD_W*c -: WORD_W])
        );
    end
endmodule

// File: rtl/aes_inv_core.sv
module aes_inv_core
    import aes_inv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [1:0]           key_len_i,
    input  logic [BLOCK_W-1:0]   cipher_i,
    output logic [RK_ADDR_W-1:0] rk_addr_o,
    input  logic [WORD_W-1:0]    rk_data_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [BLOCK_W-1:0]   plain_o
);
    core_q_t q, d;
    logic [BLOCK_W-1:0] rk_full;
    logic [BLOCK_W-1:0] round_out;

    assign rk_full = {q.rk0, q.rk1, q.rk2, rk_data_i};

    aes_inv_round i_round (
        .state_i (q.st),
        .rk_i    (rk_full),
        .last_i  (q.k == '0),
        .state_o (round_out)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.nr   = rounds_for(key_len_i);
                d.k    = rounds_for(key_len_i);
                d.w    = '0;
                d.st   = cipher_i;
            end
        end else if (q.w != W_W'(FETCH_LAST)) begin
            case (q.w)
                W_W'(1): d.rk0 = rk_data_i;
                W_W'(2): d.rk1 = rk_data_i;
                W_W'(3): d.rk2 = rk_data_i;
                default: ;
            endcase
            d.w = q.w + W_W'(1);
        end else begin
            d.w  = '0;
            d.st = (q.k == q.nr) ? (q.st ^ rk_full) : round_out;
            if (q.k == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.k = q.k - K_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rk_addr_o = {q.k, q.w[1:0]};
    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign plain_o   = q.st;

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    assert_round_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.nr == K_W'(10) || q.nr == K_W'(12) || q.nr == K_W'(14)));
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.w != '0 && q.w != W_W'(FETCH_LAST)) |-> rk_addr_o == $past(rk_addr_o) + RK_ADDR_W'(1));
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> rk_addr_o <= {q.nr, 2'b11});
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.nr));
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(plain_o));

endmodule

// File: tb/test_aes_inv_core.sv
module test_aes_inv_core;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   key_len = 2'd0;
    logic [127:0] cipher = '0;
    logic [5:0]   rk_addr;
    logic [31:0]  rk_data;
    logic         busy, done;
    logic [127:0] plain;
    logic [31:0]  rk_mem [0:63];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) rk_data <= rk_mem[rk_addr];

    aes_inv_core i_aes_inv_core (
        .clk(clk), .rst_n(rst_n), .start_i(start), .key_len_i(key_len),
        .cipher_i(cipher), .rk_addr_o(rk_addr), .rk_data_i(rk_data),
        .busy_o(busy), .done_o(done), .plain_o(plain)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction
    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = xt(x);
        end
        return p;
    endfunction
    function automatic logic [7:0] fwd_sbox(input logic [7:0] a);
        logic [7:0] v = 8'h00;
        for (int i = 1; i < 256; i++) if (mul(a, 8'(i)) == 8'h01) v = 8'(i);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction
    function automatic logic [31:0] subw(input logic [31:0] w);
        return {fwd_sbox(w[31:24]), fwd_sbox(w[23:16]), fwd_sbox(w[15:8]), fwd_sbox(w[7:0])};
    endfunction
    function automatic int nr_of(input logic [1:0] kl);
        return kl == 2'd0 ? 10 : (kl == 2'd1 ? 12 : 14);
    endfunction

    task automatic expand(input logic [255:0] key, input logic [1:0] kl);
        int nk = (kl == 2'd0) ? 4 : ((kl == 2'd1) ? 6 : 8);
        int nr = nr_of(kl);
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 64; i++) rk_mem[i] = 32'h0;
        for (int i = 0; i < nk; i++) rk_mem[i] = key[255-32*i -: 32];
        for (int i = nk; i < 4*(nr+1); i++) begin
            logic [31:0] t = rk_mem[i-1];
            if (i % nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = xt(rc);
            end else if (nk == 8 && i % nk == 4) begin
                t = subw(t);
            end
            rk_mem[i] = rk_mem[i-nk] ^ t;
        end
    endtask

    function automatic logic [127:0] rkey(input int r);
        return {rk_mem[4*r], rk_mem[4*r+1], rk_mem[4*r+2], rk_mem[4*r+3]};
    endfunction

    function automatic logic [127:0] encrypt(input logic [127:0] pt, input int nr);
        logic [127:0] s = pt ^ rkey(0);
        for (int rd = 1; rd <= nr; rd++) begin
            logic [127:0] t;
            for (int i = 0; i < 16; i++) s[127-8*i -: 8] = fwd_sbox(s[127-8*i -: 8]);
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    t[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
            s = t;
            if (rd != nr) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = s[127-32*c -: 8], a1 = s[119-32*c -: 8];
                    logic [7:0] a2 = s[111-32*c -: 8], a3 = s[103-32*c -: 8];
                    s[127-32*c -: 32] = {mul(a0,2)^mul(a1,3)^a2^a3, a0^mul(a1,2)^mul(a2,3)^a3,
                                         a0^a1^mul(a2,2)^mul(a3,3), mul(a0,3)^a1^a2^mul(a3,2)};
                end
            end
            s ^= rkey(rd);
        end
        return s;
    endfunction

    // one operation; a stray start is driven when the busy-cycle count equals inject_at
    task automatic run_op(input logic [1:0] kl, input logic [127:0] ct, input logic [127:0] exp_pt,
                          input int inject_at, input string tag);
        int nr = nr_of(kl);
        int lat = 0;
        logic [5:0] first_a, min_a, max_a;
        @(negedge clk);
        start = 1'b1; key_len = kl; cipher = ct;
        @(negedge clk);
        start = 1'b0; cipher = ~ct;
        first_a = rk_addr; min_a = rk_addr; max_a = rk_addr;
        check(busy == 1'b1, {"R2 busy after start ", tag}, 128'(busy), 128'd1);
        while (!done && lat < 400) begin
            if (lat == inject_at) begin
                start = 1'b1; key_len = kl ^ 2'd1; cipher = {$urandom, $urandom, $urandom, $urandom};
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (busy) begin
                if (rk_addr < min_a) min_a = rk_addr;
                if (rk_addr > max_a) max_a = rk_addr;
            end
        end
        start = 1'b0;
        check(lat == 5*(nr+1), {"R3 R4 latency ", tag}, 128'(lat), 128'(5*(nr+1)));
        check(!busy, {"R4 busy low at done ", tag}, 128'(busy), 128'd0);
        check(first_a == 6'(4*nr), {"R5 first address ", tag}, 128'(first_a), 128'(4*nr));
        check(min_a == 0 && max_a == 6'(4*nr+3), {"R5 address span ", tag},
              {min_a, max_a}, {6'd0, 6'(4*nr+3)});
        check(plain == exp_pt, {"R6 R7 plaintext ", tag}, plain, exp_pt);
        @(negedge clk);
        check(!done && !busy, {"R4 single-cycle done ", tag}, 128'(done), 128'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] pt, ct, held;
        logic [255:0] key;
        logic [1:0] kl;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) rk_mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(!busy && !done && plain == '0, "R1 reset state", {busy, done, plain[125:0]}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && plain == '0, "R1 after release", {busy, done, plain[125:0]}, 128'd0);

        // standard vectors for the three key lengths
        expand(256'h000102030405060708090a0b0c0d0e0f << 128, 2'd0);
        run_op(2'd0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, -1, "k128 vector");
        expand({192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, 2'd1);
        run_op(2'd1, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, 128'h00112233445566778899aabbccddeeff, -1, "k192 vector");
        expand(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 2'd2);
        run_op(2'd2, 128'h8ea2b7ca516745bfeafc49904b496089, 128'h00112233445566778899aabbccddeeff, -1, "k256 vector");
        run_op(2'd3, 128'h8ea2b7ca516745bfeafc49904b496089, 128'h00112233445566778899aabbccddeeff, -1, "R3 reserved code");

        // R8: stray starts at the first busy cycle, mid-run and just before completion
        expand(256'h000102030405060708090a0b0c0d0e0f << 128, 2'd0);
        run_op(2'd0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, 0, "R8 early start");
        run_op(2'd0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, 27, "R8 mid start");
        run_op(2'd0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, 54, "R8 late start");

        // R9: result held while the inputs move and no start comes
        held = plain;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cipher = {$urandom, $urandom, $urandom, $urandom};
            key_len = 2'($urandom);
        end
        @(negedge clk);
        check(plain == held && !busy, "R9 result held", plain, held);

        // random keys, key lengths and plaintexts
        for (int t = 0; t < 8; t++) begin
            kl  = 2'($urandom);
            key = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            pt  = {$urandom, $urandom, $urandom, $urandom};
            expand(key, kl);
            ct = encrypt(pt, nr_of(kl));
            run_op(kl, ct, pt, (t % 2 == 1) ? int'($urandom % 40) : -1, "R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule